// File: doc/BRIEF.md
# Bridge configuration cycle translator

This block sits on the downstream side of a PCI-to-PCI bridge and turns configuration requests arriving from upstream into address-phase descriptors for the secondary side. Each request names a bus, a device, a function and a dword register, and carries write data. The block compares the bus number with two plain control inputs that hold the programmed secondary and subordinate bus numbers, and then does one of four things with the request:

- **Type 0 access.** A request for the secondary bus itself becomes a Type 0 access, and the device number selects a single IDSEL line in the upper address bits.
- **Type 1 access.** A request for a bus further downstream is passed along as a Type 1 access.
- **Shutdown special cycle.** One reserved write pattern on the secondary bus becomes a Special Cycle carrying the Shutdown message instead of a configuration write.
- **Local completion.** A request for a device with no IDSEL line master-aborts inside the block. A request for a bus the bridge does not own is flagged as unsupported.

Both the request port and the descriptor port use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. The block holds one request at a time, and `req_ready` is low while a descriptor waits. A descriptor stays valid and unchanged until the consumer raises `dn_ready`. Once it is consumed, the next request can be accepted in the following cycle. A master abort or an unsupported request never produces a descriptor. Each reports through a one-cycle pulse and leaves the block ready.

Top module: `cfg_xlate`

## Requirements
- R1: In the cycle after acceptance, a request with bus equal to `sec_bus` and a device below 16 (other than the Shutdown case of R2) presents the following descriptor:
  - `dn_kind` is 2'b00.
  - `dn_addr` has exactly one bit set in bits 31:16, namely bit 16+device.
  - `dn_addr` bits 15:11 are zero, bits 10:8 are the function, bits 7:2 are the register, and bits 1:0 are 2'b00.
  - `dn_data` and `dn_write` equal the request's data and write flag.
- R2: A write is converted into a Shutdown special cycle when all of these hold: bus equals `sec_bus`, the device is 5'b11111, the function is 3'b111, the register is 6'b000000 and the data is zero. The descriptor then has `dn_kind` 2'b10, `dn_write` 1, `dn_addr` zero, and `dn_data` holding the Shutdown message code 16'h0000 in bits 15:0 with zeros above.
- R3: A request that differs from the R2 pattern in any single field is handled as an ordinary request and produces no special cycle. The differing field may be the data, the function, the register, the device or the bus.
- R4: A request on the secondary bus with a device of 16 or more, other than the R2 case, produces no descriptor. One cycle after acceptance, `cpl_abort` pulses high for exactly one cycle and `cpl_rdata` is all ones.
- R5: A read whose fields match the R2 pattern is not converted. It master-aborts as in R4.
- R6: A request with `sec_bus` < bus <= `sub_bus` presents the following descriptor in the cycle after acceptance:
  - `dn_kind` is 2'b01.
  - `dn_addr` is {8'h00, bus, device, function, register, 2'b01}.
  - `dn_data` and `dn_write` equal the request's data and write flag.
- R7: A request whose bus is below `sec_bus` or above `sub_bus` produces no descriptor and no abort. `ur_flag` pulses high for exactly one cycle, one cycle after acceptance.
- R8: `req_ready` is low whenever `dn_valid` is high. While `dn_valid` is high and `dn_ready` is low, the descriptor fields stay unchanged. `dn_valid` falls after the edge where `dn_ready` is high, and a request held waiting is accepted only in a later cycle.
- R9: During and immediately after reset, `dn_valid`, `cpl_abort` and `ur_flag` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_bus | input | 8 | Programmed secondary bus number |
| sub_bus | input | 8 | Programmed subordinate bus number |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = configuration write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_reg | input | 6 | Target dword register index |
| req_data | input | 32 | Write data |
| dn_valid | output | 1 | Descriptor valid |
| dn_ready | input | 1 | Downstream consumer takes the descriptor |
| dn_kind | output | 2 | 00 Type 0, 01 Type 1, 10 Special Cycle |
| dn_write | output | 1 | Descriptor direction, 1 = write |
| dn_addr | output | 32 | Address-phase value |
| dn_data | output | 32 | Data or special-cycle message |
| cpl_abort | output | 1 | One-cycle master-abort completion pulse |
| cpl_rdata | output | 32 | Read data returned with an abort (all ones) |
| ur_flag | output | 1 | One-cycle unsupported-request pulse |

## Verification
The bench builds the block with its default parameters: 8-bit buses, a 5-bit device field, 16 IDSEL lines starting at address bit 16, and 32-bit data. It ties the secondary bus to 4 and the subordinate bus to 6. With these settings, a sweep of all 32 device numbers in both directions covers every IDSEL line and every aborting device. A sweep of bus numbers 0 to 9 reaches both sides of the owned range and each of its edges. The Shutdown pattern is tried exactly, as a read, and with each field changed by one step. A stalled consumer, with a second request held waiting, exercises the back-pressure rules.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  typedef enum logic [1:0] {
    K_TYPE0   = 2'b00,
    K_TYPE1   = 2'b01,
    K_SPECIAL = 2'b10
  } dn_kind_e;

  typedef enum logic [1:0] {
    ACT_FWD   = 2'b00,
    ACT_ABORT = 2'b01,
    ACT_UR    = 2'b10
  } act_e;

  localparam logic [15:0] MSG_SHUTDOWN = 16'h0000;
endpackage

// File: rtl/cfg_classify.sv
module cfg_classify
  import cfg_xlate_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int FN_W      = 3,
  parameter int REG_W     = 6,
  parameter int DATA_W    = 32,
  parameter int IDSEL_CNT = 16
) (
  input  logic              write,
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FN_W-1:0]   fn,
  input  logic [REG_W-1:0]  regn,
  input  logic [DATA_W-1:0] data,
  input  logic [BUS_W-1:0]  sec_bus,
  input  logic [BUS_W-1:0]  sub_bus,
  output act_e              act,
  output dn_kind_e          kind
);
  localparam logic [DEV_W:0] DEV_LIMIT = (DEV_W+1)'(IDSEL_CNT);

  logic on_sec;
  logic behind;
  logic shutdown_hit;
  logic has_idsel;

  assign on_sec       = (bus == sec_bus);
  assign behind       = (bus > sec_bus) && (bus <= sub_bus);
  assign shutdown_hit = write && on_sec && (&dev) && (&fn) &&
                        (regn == '0) && (data == '0);
  assign has_idsel    = ({1'b0, dev} < DEV_LIMIT);

  always_comb begin
    act  = ACT_UR;
    kind = K_TYPE0;
    if (on_sec) begin
      if (shutdown_hit) begin
        act  = ACT_FWD;
        kind = K_SPECIAL;
      end else if (has_idsel) begin
        act  = ACT_FWD;
        kind = K_TYPE0;
      end else begin
        act  = ACT_ABORT;
      end
    end else if (behind) begin
      act  = ACT_FWD;
      kind = K_TYPE1;
    end
  end
endmodule

// File: rtl/cfg_addr_build.sv
module cfg_addr_build
  import cfg_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUS_W      = 8,
  parameter int DEV_W      = 5,
  parameter int FN_W       = 3,
  parameter int REG_W      = 6,
  parameter int IDSEL_BASE = 16,
  parameter int IDSEL_CNT  = 16
) (
  input  dn_kind_e          kind,
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FN_W-1:0]   fn,
  input  logic [REG_W-1:0]  regn,
  output logic [ADDR_W-1:0] addr
);
  localparam int LOW_W = FN_W + REG_W + 2;
  localparam int T1_W  = BUS_W + DEV_W + LOW_W;

  logic [IDSEL_CNT-1:0] idsel;

  generate
    for (genvar i = 0; i < IDSEL_CNT; i++) begin : g_idsel
      assign idsel[i] = (dev == DEV_W'(i));
    end
  endgenerate

  always_comb begin
    addr = '0;
    unique case (kind)
      K_TYPE0: begin
        addr[IDSEL_BASE +: IDSEL_CNT] = idsel;
        addr[LOW_W-1:0]               = {fn, regn, 2'b00};
      end
      K_TYPE1: begin
        addr[T1_W-1:0] = {bus, dev, fn, regn, 2'b01};
      end
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/cfg_desc_hold.sv
module cfg_desc_hold
  import cfg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  dn_kind_e          kind_in,
  input  logic              write_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              dn_ready,
  output logic              dn_valid,
  output dn_kind_e          dn_kind,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_kind  <= K_TYPE0;
      dn_write <= 1'b0;
      dn_addr  <= '0;
      dn_data  <= '0;
    end else if (load) begin
      dn_valid <= 1'b1;
      dn_kind  <= kind_in;
      dn_write <= write_in;
      dn_addr  <= addr_in;
      dn_data  <= data_in;
    end else if (dn_ready) begin
      dn_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int BUS_W      = 8,
  parameter int DEV_W      = 5,
  parameter int FN_W       = 3,
  parameter int REG_W      = 6,
  parameter int IDSEL_BASE = 16,
  parameter int IDSEL_CNT  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  sec_bus,
  input  logic [BUS_W-1:0]  sub_bus,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [1:0]        dn_kind,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_data,
  output logic              cpl_abort,
  output logic [DATA_W-1:0] cpl_rdata,
  output logic              ur_flag
);
  localparam int LOW_W = FN_W + REG_W + 2;

  initial begin
    if (IDSEL_BASE < LOW_W || IDSEL_BASE + IDSEL_CNT > ADDR_W)
      $error("cfg_xlate: IDSEL window does not fit the address");
    if (BUS_W + DEV_W + LOW_W > ADDR_W || DATA_W < 16)
      $error("cfg_xlate: field widths do not fit");
  end

  act_e              act;
  dn_kind_e          kind;
  dn_kind_e          kind_q;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] desc_data;
  logic              desc_write;
  logic              accept;

  assign req_ready = !dn_valid;
  assign accept    = req_valid && req_ready;

  cfg_classify #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .REG_W(REG_W),
    .DATA_W(DATA_W), .IDSEL_CNT(IDSEL_CNT)
  ) u_cls (
    .write(req_write), .bus(req_bus), .dev(req_dev), .fn(req_fn),
    .regn(req_reg), .data(req_data), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .act(act), .kind(kind)
  );

  cfg_addr_build #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W),
    .REG_W(REG_W), .IDSEL_BASE(IDSEL_BASE), .IDSEL_CNT(IDSEL_CNT)
  ) u_adr (
    .kind(kind), .bus(req_bus), .dev(req_dev), .fn(req_fn),
    .regn(req_reg), .addr(addr)
  );

  always_comb begin
    if (kind == K_SPECIAL) begin
      desc_data  = {{(DATA_W-16){1'b0}}, MSG_SHUTDOWN};
      desc_write = 1'b1;
    end else begin
      desc_data  = req_data;
      desc_write = req_write;
    end
  end

  cfg_desc_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load(accept && (act == ACT_FWD)),
    .kind_in(kind), .write_in(desc_write), .addr_in(addr), .data_in(desc_data),
    .dn_ready(dn_ready), .dn_valid(dn_valid), .dn_kind(kind_q),
    .dn_write(dn_write), .dn_addr(dn_addr), .dn_data(dn_data)
  );

  assign dn_kind   = kind_q;
  assign cpl_rdata = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpl_abort <= 1'b0;
      ur_flag   <= 1'b0;
    end else begin
      cpl_abort <= accept && (act == ACT_ABORT);
      ur_flag   <= accept && (act == ACT_UR);
    end
  end
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IDSEL_BASE = 16,
  parameter int IDSEL_CNT  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [1:0]        dn_kind,
  input logic              dn_write,
  input logic [ADDR_W-1:0] dn_addr,
  input logic [DATA_W-1:0] dn_data,
  input logic              cpl_abort,
  input logic              ur_flag
);
  // R8: a stalled descriptor keeps every field
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) &&
      $stable(dn_kind) && $stable(dn_data) && $stable(dn_write));

  // R8: one request in flight
  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !req_ready);

  // R1: Type 0 selects exactly one IDSEL line
  a_r1_idsel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_kind == 2'b00 |->
      $countones(dn_addr[IDSEL_BASE +: IDSEL_CNT]) == 1 && dn_addr[1:0] == 2'b00);

  // R6: Type 1 address tag
  a_r6_type1_tag: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_kind == 2'b01 |-> dn_addr[1:0] == 2'b01);

  // R2: special cycle is a write with zero address
  a_r2_special_write: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_kind == 2'b10 |-> dn_write && dn_addr == '0);

  // R4: abort only follows an accepted request
  a_r4_abort_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_abort |-> $past(req_valid && req_ready) && !$rose(dn_valid));

  // R7: unsupported flag only follows an accepted request, never with an abort
  a_r7_ur_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ur_flag |-> $past(req_valid && req_ready) && !cpl_abort && !$rose(dn_valid));
endmodule

bind cfg_xlate cfg_xlate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDSEL_BASE(IDSEL_BASE), .IDSEL_CNT(IDSEL_CNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_kind(dn_kind), .dn_write(dn_write),
  .dn_addr(dn_addr), .dn_data(dn_data), .cpl_abort(cpl_abort), .ur_flag(ur_flag)
);

// File: tb/cfg_xlate_test.sv
`timescale 1ns/1ps
module cfg_xlate_test;
  localparam logic [7:0] SEC = 8'd4;
  localparam logic [7:0] SUB = 8'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, dn_ready = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [5:0]  req_reg = '0;
  logic [31:0] req_data = '0;
  logic        req_ready, dn_valid, dn_write, cpl_abort, ur_flag;
  logic [1:0]  dn_kind;
  logic [31:0] dn_addr, dn_data, cpl_rdata;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cfg_xlate uut (
    .clk(clk), .rst_n(rst_n), .sec_bus(SEC), .sub_bus(SUB),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn), .req_reg(req_reg),
    .req_data(req_data), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_kind(dn_kind), .dn_write(dn_write), .dn_addr(dn_addr), .dn_data(dn_data),
    .cpl_abort(cpl_abort), .cpl_rdata(cpl_rdata), .ur_flag(ur_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // outcome codes: 0 Type0, 1 Type1, 2 special, 3 abort, 4 unsupported
  task automatic run_one(input bit w, input logic [7:0] bus, input logic [4:0] dev,
                         input logic [2:0] fn, input logic [5:0] rg,
                         input logic [31:0] data, input string tag);
    int outc;
    logic [31:0] ea, ed;
    bit shut;
    shut = w && bus == SEC && dev == 5'd31 && fn == 3'd7 && rg == 6'd0 && data == 0;
    if (bus == SEC) outc = shut ? 2 : (dev < 16 ? 0 : 3);
    else if (bus > SEC && bus <= SUB) outc = 1;
    else outc = 4;
    ea = 0;
    ed = data;
    if (outc == 0) ea = (32'd1 << (16 + dev)) | (32'(fn) << 8) | (32'(rg) << 2);
    if (outc == 1) ea = (32'(bus) << 16) | (32'(dev) << 11) | (32'(fn) << 8) |
                        (32'(rg) << 2) | 32'd1;
    if (outc == 2) ed = 32'h0000_0000;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bus = bus; req_dev = dev;
    req_fn = fn; req_reg = rg; req_data = data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (outc <= 2) begin
      chk(dn_valid == 1'b1, {tag, " dn_valid"}, 32'(dn_valid), 1);
      chk(dn_kind == 2'(outc), {tag, " dn_kind"}, 32'(dn_kind), 32'(outc));
      chk(dn_addr == ea, {tag, " dn_addr"}, dn_addr, ea);
      chk(dn_data == ed, {tag, " dn_data"}, dn_data, ed);
      chk(dn_write == (outc == 2 ? 1'b1 : w), {tag, " dn_write"}, 32'(dn_write),
          32'(outc == 2 ? 1'b1 : w));
      chk(!cpl_abort && !ur_flag, {tag, " no pulse"}, {30'd0, cpl_abort, ur_flag}, 0);
      dn_ready = 1'b1;
      @(negedge clk);
      dn_ready = 1'b0;
      chk(dn_valid == 1'b0, "R8 consumed", 32'(dn_valid), 0);
    end else if (outc == 3) begin
      chk(cpl_abort == 1'b1, {tag, " abort"}, 32'(cpl_abort), 1);
      chk(cpl_rdata == 32'hFFFF_FFFF, {tag, " abort rdata"}, cpl_rdata, 32'hFFFF_FFFF);
      chk(!dn_valid && !ur_flag, {tag, " no descriptor"}, {30'd0, dn_valid, ur_flag}, 0);
      @(negedge clk);
      chk(cpl_abort == 1'b0, {tag, " abort one cycle"}, 32'(cpl_abort), 0);
    end else begin
      chk(ur_flag == 1'b1, {tag, " ur"}, 32'(ur_flag), 1);
      chk(!dn_valid && !cpl_abort, {tag, " no descriptor"}, {30'd0, dn_valid, cpl_abort}, 0);
      @(negedge clk);
      chk(ur_flag == 1'b0, {tag, " ur one cycle"}, 32'(ur_flag), 0);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!dn_valid && !cpl_abort && !ur_flag && req_ready, "R9 in reset",
        {28'd0, dn_valid, cpl_abort, ur_flag, req_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dn_valid && !cpl_abort && !ur_flag && req_ready, "R9 after reset",
        {28'd0, dn_valid, cpl_abort, ur_flag, req_ready}, 1);

    // R1 / R4: every device on the secondary bus, both directions
    for (int d = 0; d < 32; d++) begin
      for (int w = 0; w < 2; w++) begin
        run_one(w[0], SEC, 5'(d), 3'(d % 8), 6'((d * 3 + w) % 64),
                32'hA500_0000 + 32'(d * 2 + w), d < 16 ? "R1" : "R4");
      end
    end

    // R6 / R7: bus sweep across and around the owned range
    for (int b = 0; b < 10; b++) begin
      for (int w = 0; w < 2; w++) begin
        run_one(w[0], 8'(b), 5'd9, 3'd5, 6'd33, 32'h1234_0000 + 32'(b),
                (b > 4 && b <= 6) ? "R6" : (b == 4 ? "R1" : "R7"));
      end
    end
    run_one(1'b1, 8'd6, 5'd31, 3'd7, 6'd63, 32'hFFFF_FFFF, "R6 upper fields");

    // R2 exact pattern, R5 as a read, R3 single-field misses
    run_one(1'b1, SEC, 5'd31, 3'd7, 6'd0, 32'd0, "R2");
    run_one(1'b0, SEC, 5'd31, 3'd7, 6'd0, 32'd0, "R5");
    run_one(1'b1, SEC, 5'd31, 3'd7, 6'd0, 32'd1, "R3 data");
    run_one(1'b1, SEC, 5'd31, 3'd7, 6'd0, 32'h8000_0000, "R3 data msb");
    run_one(1'b1, SEC, 5'd31, 3'd6, 6'd0, 32'd0, "R3 function");
    run_one(1'b1, SEC, 5'd31, 3'd7, 6'd1, 32'd0, "R3 register");
    run_one(1'b1, SEC, 5'd30, 3'd7, 6'd0, 32'd0, "R3 device");
    run_one(1'b1, 8'd5, 5'd31, 3'd7, 6'd0, 32'd0, "R3 bus");
    run_one(1'b1, 8'd3, 5'd31, 3'd7, 6'd0, 32'd0, "R3 bus below");

    // R8: stall with a second request held waiting
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_bus = 8'd5; req_dev = 5'd2;
    req_fn = 3'd1; req_reg = 6'd4; req_data = 32'h0000_AAAA;
    @(posedge clk);
    @(negedge clk);
    req_bus = SEC; req_dev = 5'd7; req_fn = 3'd2; req_reg = 6'd8; req_data = 32'h0000_BBBB;
    for (int i = 0; i < 3; i++) begin
      chk(dn_valid && !req_ready, "R8 stall", {30'd0, dn_valid, req_ready}, 2);
      chk(dn_addr == 32'h0005_1111 && dn_data == 32'h0000_AAAA, "R8 stall hold",
          dn_addr, 32'h0005_1111);
      @(negedge clk);
    end
    dn_ready = 1'b1;
    @(negedge clk);
    dn_ready = 1'b0;
    chk(dn_valid == 1'b0 && req_ready, "R8 release", {30'd0, dn_valid, req_ready}, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(dn_valid && dn_kind == 2'b00, "R8 waiting accepted", {30'd0, dn_kind}, 0);
    chk(dn_addr == 32'h0080_0220, "R8 waiting addr", dn_addr, 32'h0080_0220);
    chk(dn_data == 32'h0000_BBBB, "R8 waiting data", dn_data, 32'h0000_BBBB);
    dn_ready = 1'b1;
    @(negedge clk);
    dn_ready = 1'b0;
    chk(dn_valid == 1'b0, "R8 final consume", 32'(dn_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule